// File: doc/BRIEF.md
# Output Driver Short-Circuit Supervisor with Autoretry

This block watches a single 24 V output driver and decides when the driver has a fault and when it must be switched off. It takes a synchronized over-current flag from the current limiter. It also takes three level-check signals: whether the driver is in open-drain mode, whether the driver is commanded on, and whether the line voltage sits between the receiver thresholds. Every duration is counted in ticks of a one-cycle strobe, nominally 1 µs. Four parameters set the durations: the registration delay, the kill delay, the retry window and the retry period. The defaults suit the line driver, and an auxiliary output driver uses the same module with its own values.

A short follows this state machine: `S_IDLE` goes to `S_QUAL` on over-current. `S_QUAL` goes to `S_TRIP` when the registration count is reached, or back to `S_IDLE` if the over-current drops. `S_TRIP` goes to `S_OFF` when the kill count is reached, or to `S_IDLE` if the over-current drops. `S_OFF` goes to `S_RETRY` when the off time has passed. `S_RETRY` goes back to `S_OFF` if any over-current was seen during the window, or to `S_IDLE` if the window stayed clean. A separate level monitor (`L_IDLE`, `L_QUAL`, `L_FAULT`) registers a level fault when the level condition persists. This monitor is present only when the `LEVEL_CHECK` parameter is 1.

Top module: `drv_fault_supervisor`

## Requirements
- R1: After reset, `kill_o`, `fault_o` and `irq_o` are all 0.
- R2: Over-current held continuously for REG_TICKS ticks registers a fault. On the REG_TICKS-th tick, `fault_o` rises and `irq_o` pulses in the same cycle.
- R3: Over-current that ends before REG_TICKS ticks causes no change on any output, and the next over-current is timed again from zero.
- R4: Over-current held for KILL_TICKS ticks from its start raises `kill_o` on the KILL_TICKS-th tick.
- R5: If the over-current ends after the fault has registered but before the kill, `fault_o` falls in the cycle after the drop and `kill_o` never rises.
- R6: Once `kill_o` is high, it falls after exactly PERIOD_TICKS-RETRY_TICKS ticks, which opens a retry window. Over-current during this off time has no effect.
- R7: If over-current is present at any cycle of a retry window, `kill_o` rises again on the window's last tick. This is PERIOD_TICKS ticks after the previous rise.
- R8: If a retry window passes with no over-current, autoretry ends. `fault_o` falls on the window's last tick and `kill_o` stays low.
- R9: With LEVEL_CHECK=1, the level condition (`od_mode_i`=1, `drv_on_i`=0, `line_mid_i`=1) held for REG_TICKS ticks raises `fault_o` and pulses `irq_o`, with no kill. `fault_o` falls in the cycle after the condition ends. When `od_mode_i`=0, the level check has no effect.
- R10: `irq_o` is high for exactly one cycle per registered fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase strobe (1 µs nominal) |
| ovc_i | input | 1 | Synchronized over-current flag |
| od_mode_i | input | 1 | Driver is in open-drain mode (1) or push-pull mode (0) |
| drv_on_i | input | 1 | Driver is commanded on |
| line_mid_i | input | 1 | Line is between the low and high receiver thresholds |
| kill_o | output | 1 | Forces the driver off |
| fault_o | output | 1 | Live fault status |
| irq_o | output | 1 | One-cycle fault interrupt strobe |

## Verification
The assertions assume that `tick_i` is a single-cycle strobe separated by at least one idle cycle. They also assume that the parameters satisfy REG_TICKS < KILL_TICKS and RETRY_TICKS < PERIOD_TICKS. Under those assumptions, every rise or fall of the kill signal must follow a tick, and every interrupt is a lone cycle. The stimulus toggles the tick every cycle, which gives one tick every two clocks. It changes over-current and the level inputs only in the cycle where a tick has just been issued, so every timed event falls on a known tick number. The stimulus never drives a short and a level error at the same time.

// File: rtl/fsv_pkg.sv
package fsv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_QUAL,
        S_TRIP,
        S_OFF,
        S_RETRY
    } short_state_e;

    typedef enum logic [1:0] {
        L_IDLE,
        L_QUAL,
        L_FAULT
    } level_state_e;

endpackage

// File: rtl/fsv_short_fsm.sv
module fsv_short_fsm
    import fsv_pkg::*;
#(
    parameter int unsigned REG_TICKS    = 160,
    parameter int unsigned KILL_TICKS   = 240,
    parameter int unsigned RETRY_TICKS  = 350,
    parameter int unsigned PERIOD_TICKS = 26000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ovc_i,
    output logic kill_o,
    output logic fault_o,
    output logic reg_stb_o
);
    localparam int unsigned OFF_TICKS = PERIOD_TICKS - RETRY_TICKS;
    localparam int unsigned CW = $clog2(PERIOD_TICKS + KILL_TICKS + 1);
    localparam logic [CW-1:0] REG_C   = CW'(REG_TICKS);
    localparam logic [CW-1:0] KILL_C  = CW'(KILL_TICKS);
    localparam logic [CW-1:0] OFF_C   = CW'(OFF_TICKS);
    localparam logic [CW-1:0] RETRY_C = CW'(RETRY_TICKS);

    short_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          seen_q, seen_d;
    logic          stb_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        seen_d  = seen_q;
        unique case (state_q)
            S_IDLE: begin
                if (ovc_i) begin
                    state_d = S_QUAL;
                    cnt_d   = '0;
                end
            end
            S_QUAL: begin
                if (!ovc_i) begin
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == REG_C) state_d = S_TRIP;
                end
            end
            S_TRIP: begin
                if (!ovc_i) begin
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == KILL_C) begin
                        state_d = S_OFF;
                        cnt_d   = '0;
                    end
                end
            end
            S_OFF: begin
                if (tick_i) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == OFF_C) begin
                        state_d = S_RETRY;
                        cnt_d   = '0;
                        seen_d  = 1'b0;
                    end
                end
            end
            S_RETRY: begin
                seen_d = seen_q | ovc_i;
                if (tick_i) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == RETRY_C) begin
                        cnt_d   = '0;
                        state_d = (seen_q | ovc_i) ? S_OFF : S_IDLE;
                    end
                end
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            seen_q  <= seen_d;
            stb_q   <= (state_q == S_QUAL) && (state_d == S_TRIP);
        end
    end

    // outputs
    always_comb begin
        kill_o    = (state_q == S_OFF);
        fault_o   = (state_q == S_TRIP) || (state_q == S_OFF) || (state_q == S_RETRY);
        reg_stb_o = stb_q;
    end

endmodule

// File: rtl/fsv_level_mon.sv
module fsv_level_mon
    import fsv_pkg::*;
#(
    parameter int unsigned REG_TICKS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic cond_i,
    output logic fault_o,
    output logic reg_stb_o
);
    localparam int unsigned CW = $clog2(REG_TICKS + 1);
    localparam logic [CW-1:0] REG_C = CW'(REG_TICKS);

    level_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          stb_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            L_IDLE: begin
                if (cond_i) begin
                    state_d = L_QUAL;
                    cnt_d   = '0;
                end
            end
            L_QUAL: begin
                if (!cond_i) begin
                    state_d = L_IDLE;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == REG_C) state_d = L_FAULT;
                end
            end
            L_FAULT: begin
                if (!cond_i) begin
                    state_d = L_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = L_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= L_IDLE;
            cnt_q   <= '0;
            stb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            stb_q   <= (state_q == L_QUAL) && (state_d == L_FAULT);
        end
    end

    always_comb begin
        fault_o   = (state_q == L_FAULT);
        reg_stb_o = stb_q;
    end

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
    parameter int unsigned REG_TICKS    = 160,
    parameter int unsigned KILL_TICKS   = 240,
    parameter int unsigned RETRY_TICKS  = 350,
    parameter int unsigned PERIOD_TICKS = 26000,
    parameter bit          LEVEL_CHECK  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ovc_i,
    input  logic od_mode_i,
    input  logic drv_on_i,
    input  logic line_mid_i,
    output logic kill_o,
    output logic fault_o,
    output logic irq_o
);
    logic short_fault, short_stb;
    logic lvl_fault, lvl_stb;

    fsv_short_fsm #(
        .REG_TICKS   (REG_TICKS),
        .KILL_TICKS  (KILL_TICKS),
        .RETRY_TICKS (RETRY_TICKS),
        .PERIOD_TICKS(PERIOD_TICKS)
    ) u_short (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .ovc_i    (ovc_i),
        .kill_o   (kill_o),
        .fault_o  (short_fault),
        .reg_stb_o(short_stb)
    );

    generate
        if (LEVEL_CHECK) begin : g_level
            logic lvl_cond;
            assign lvl_cond = od_mode_i & ~drv_on_i & line_mid_i;
            fsv_level_mon #(
                .REG_TICKS(REG_TICKS)
            ) u_level (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_i   (tick_i),
                .cond_i   (lvl_cond),
                .fault_o  (lvl_fault),
                .reg_stb_o(lvl_stb)
            );
        end else begin : g_no_level
            assign lvl_fault = 1'b0;
            assign lvl_stb   = 1'b0;
        end
    endgenerate

    assign fault_o = short_fault | lvl_fault;
    assign irq_o   = short_stb | lvl_stb;

endmodule

// File: rtl/fsv_checker.sv
module fsv_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic kill_o,
    input logic fault_o,
    input logic irq_o
);
    // R4: the driver is never forced off without a live fault
    a_r4_kill_has_fault: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |-> fault_o);

    // R10: interrupt strobe lasts a single cycle
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R2: a strobe always comes with a live fault
    a_r2_irq_has_fault: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> fault_o);

    // R2: fault only appears together with the strobe
    a_r2_fault_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> irq_o);

    // R6: kill rises only on a timebase tick
    a_r6_kill_rise_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kill_o) |-> $past(tick_i));

    // R7: kill falls only on a timebase tick
    a_r7_kill_fall_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kill_o) |-> $past(tick_i));

endmodule

bind drv_fault_supervisor fsv_checker u_fsv_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .kill_o (kill_o),
    .fault_o(fault_o),
    .irq_o  (irq_o)
);

// File: tb/drv_fault_supervisor_test.sv
module drv_fault_supervisor_test;

    localparam int REG    = 8;
    localparam int KILL   = 12;
    localparam int RETRY  = 6;
    localparam int PERIOD = 40;
    localparam int OFFT   = PERIOD - RETRY;

    typedef enum int {EV_IRQ, EV_FUP, EV_FDN, EV_KUP, EV_KDN} ev_e;
    typedef struct {
        ev_e   kind;
        int    tk;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic ovc = 1'b0;
    logic od = 1'b0;
    logic drv_on = 1'b1;
    logic mid = 1'b0;
    logic kill, fault, irq;

    int tk_cnt = 0;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    item_t exp_q[$];

    always #5 clk = ~clk;

    drv_fault_supervisor #(
        .REG_TICKS   (REG),
        .KILL_TICKS  (KILL),
        .RETRY_TICKS (RETRY),
        .PERIOD_TICKS(PERIOD),
        .LEVEL_CHECK (1'b1)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .ovc_i     (ovc),
        .od_mode_i (od),
        .drv_on_i  (drv_on),
        .line_mid_i(mid),
        .kill_o    (kill),
        .fault_o   (fault),
        .irq_o     (irq)
    );

    // timebase: one tick every two clocks, numbered
    always @(negedge clk) begin
        if (rst_n) begin
            tick <= ~tick;
            if (!tick) tk_cnt <= tk_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input ev_e k, input int t, input string req);
        item_t it;
        it.kind = k;
        it.tk   = t;
        it.req  = req;
        exp_q.push_back(it);
    endtask

    task automatic at_tick(input int n);
        do begin
            @(negedge clk);
            #1;
        end while (!(tick && tk_cnt == n));
    endtask

    task automatic check_quiet(input string req);
        chk(exp_q.size() == 0, req, "pending events", exp_q.size(), 0);
        chk(kill == 1'b0, req, "kill idle", int'(kill), 0);
        chk(fault == 1'b0, req, "fault idle", int'(fault), 0);
    endtask

    // monitor: compare observed edges against the scoreboard queue
    task automatic observe(input ev_e k);
        item_t it;
        if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected", "event kind", int'(k), -1);
        end else begin
            it = exp_q.pop_front();
            chk(it.kind == k, it.req, "event kind", int'(k), int'(it.kind));
            chk(it.tk == tk_cnt, it.req, "event tick", tk_cnt, it.tk);
        end
    endtask

    initial begin
        logic pk, pf, pi;
        pk = 1'b0; pf = 1'b0; pi = 1'b0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            #1;
            if (pi && irq) chk(1'b0, "R10", "irq width", 2, 1);
            if (irq && !pi) observe(EV_IRQ);
            if (fault && !pf) observe(EV_FUP);
            if (!fault && pf) observe(EV_FDN);
            if (kill && !pk) observe(EV_KUP);
            if (!kill && pk) observe(EV_KDN);
            pk = kill; pf = fault; pi = irq;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset values
        chk(kill == 1'b0, "R1", "kill", int'(kill), 0);
        chk(fault == 1'b0, "R1", "fault", int'(fault), 0);
        chk(irq == 1'b0, "R1", "irq", int'(irq), 0);
        rst_n = 1'b1;

        // R3: short glitch, then restart timed from zero; R5: early drop
        at_tick(4); t = 4;
        ovc = 1'b1;
        at_tick(t + REG - 1); ovc = 1'b0;
        at_tick(t + REG + 1); t = t + REG + 1; ovc = 1'b1;
        expect_ev(EV_IRQ, t + REG, "R2");
        expect_ev(EV_FUP, t + REG, "R3");
        expect_ev(EV_FDN, t + REG + 2, "R5");
        at_tick(t + REG + 2); ovc = 1'b0;
        at_tick(t + KILL + 4);
        check_quiet("R5");

        // R4, R6, R7, R8: persistent short, ignored pulses in off time, clean retry
        t = t + KILL + 6;
        at_tick(t); ovc = 1'b1;
        expect_ev(EV_IRQ, t + REG, "R2");
        expect_ev(EV_FUP, t + REG, "R2");
        expect_ev(EV_KUP, t + KILL, "R4");
        expect_ev(EV_KDN, t + KILL + OFFT, "R6");
        expect_ev(EV_KUP, t + KILL + PERIOD, "R7");
        expect_ev(EV_KDN, t + KILL + PERIOD + OFFT, "R6");
        expect_ev(EV_FDN, t + KILL + 2 * PERIOD, "R8");
        at_tick(t + KILL + PERIOD + 8);  ovc = 1'b0;
        at_tick(t + KILL + PERIOD + 10); ovc = 1'b1;
        at_tick(t + KILL + PERIOD + 12); ovc = 1'b0;
        at_tick(t + KILL + 2 * PERIOD + 4);
        check_quiet("R8");

        // R7: a one-tick over-current in the retry window re-arms the kill
        t = t + KILL + 2 * PERIOD + 6;
        at_tick(t); ovc = 1'b1;
        expect_ev(EV_IRQ, t + REG, "R2");
        expect_ev(EV_FUP, t + REG, "R2");
        expect_ev(EV_KUP, t + KILL, "R4");
        expect_ev(EV_KDN, t + KILL + OFFT, "R6");
        expect_ev(EV_KUP, t + KILL + PERIOD, "R7");
        expect_ev(EV_KDN, t + KILL + PERIOD + OFFT, "R6");
        expect_ev(EV_FDN, t + KILL + 2 * PERIOD, "R8");
        at_tick(t + KILL + 2); ovc = 1'b0;
        at_tick(t + KILL + OFFT + 2); ovc = 1'b1;
        at_tick(t + KILL + OFFT + 3); ovc = 1'b0;
        at_tick(t + KILL + 2 * PERIOD + 4);
        check_quiet("R7");

        // R9: level error in open-drain mode
        t = t + KILL + 2 * PERIOD + 6;
        at_tick(t); od = 1'b1; drv_on = 1'b0; mid = 1'b1;
        expect_ev(EV_IRQ, t + REG, "R9");
        expect_ev(EV_FUP, t + REG, "R9");
        expect_ev(EV_FDN, t + REG + 3, "R9");
        at_tick(t + REG + 1);
        chk(kill == 1'b0, "R9", "no kill on level fault", int'(kill), 0);
        at_tick(t + REG + 3); mid = 1'b0;
        at_tick(t + REG + 5);
        check_quiet("R9");

        // R9: push-pull mode ignores the level condition
        t = t + REG + 6;
        at_tick(t); od = 1'b0; mid = 1'b1;
        at_tick(t + 2 * REG);
        chk(fault == 1'b0, "R9", "push-pull level ignored", int'(fault), 0);
        mid = 1'b0; drv_on = 1'b1;
        at_tick(t + 2 * REG + 2);
        check_quiet("R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule